// File: doc/BRIEF.md
# Marker-Based Lane Lock

This block is the receive-side lock for a single lane of a multi-lane link that comes out of a low-power state. It takes 66-bit words cut from a serial stream whose block boundary is unknown. It looks for the lane's own 24-bit marker, preceded by the marker sync header, at every one of the 66 bit offsets in the same cycle. One search step therefore yields both the block boundary and the marker position. There is no separate sync-header hunt spread over many blocks.

When a candidate is found, the block remembers its offset. It then checks the block that lies a programmable number of blocks later at that same offset. A second match raises block lock and marker lock in the same cycle. With the default spacing of 8, lock arrives after about two marker intervals. While locked, the block keeps checking every expected marker position. Three consecutive misses drop both lock flags and restart the search. Once locked, the block also emits the aligned 66-bit blocks taken at the locked offset.

Top module: `lane_marker_lock`

## Requirements
- R1: While reset is applied and just after it, `block_lock`, `marker_lock` and `out_valid` are 0 and `bit_offset` is 0.
- R2: The stream is taken LSB first. Each cycle with `in_valid` high, the 132-bit window is formed with the previous accepted word as its low half and `in_word` as its high half. Offset k selects window bits k+65..k. That block is a marker candidate when its bits [1:0] equal 2'b01 and its bits [25:2] equal `lane_marker`. All offsets 0 to 65 are compared in the same cycle, and the chosen offset appears on `bit_offset` after that edge.
- R3: When several offsets match in the same cycle, the lowest offset is taken.
- R4: After a candidate, the valid word that comes exactly `spacing` valid words later is checked at the same offset. If it matches, `block_lock` and `marker_lock` rise together on that clock edge. For a marker in stream block j, this is the edge that accepts word j+1 for the confirming marker.
- R5: If the confirming check fails, the candidate is discarded without lock, and the parallel search resumes with the next valid word.
- R6: While locked, a marker is expected every `spacing` valid words at the locked offset. Three consecutive misses drop both lock flags on the edge of the third missed check.
- R7: A marker found at an expected position while locked clears the miss count, so misses separated by a hit do not accumulate.
- R8: A marker field that differs from `lane_marker` is never a candidate. A lane fed only with another lane's marker never locks.
- R9: While locked, each accepted word produces, one edge later, `out_valid` high with `out_block` equal to the stream block that starts in the previous accepted word at `bit_offset`. `bit_offset` stays constant while locked.
- R10: A cycle with `in_valid` low advances no count, changes no lock state and gives `out_valid` low.
- R11: `spacing` sets the marker interval. Lock timing follows it for 4, 6, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_word` holds a new stream word |
| in_word | input | 66 | Raw stream word, earliest bit in bit 0 |
| lane_marker | input | 24 | Marker pattern that identifies this lane |
| spacing | input | 8 | Blocks between markers (default use 8) |
| block_lock | output | 1 | Block boundary found |
| marker_lock | output | 1 | Marker position found (rises with block lock) |
| bit_offset | output | 7 | Selected bit offset 0..65 |
| out_valid | output | 1 | `out_block` holds a new aligned block |
| out_block | output | 66 | Aligned 66-bit block |

## Verification
The bench places markers at offsets 0, 65 and several in between, and pins the exact word on which lock rises. A design whose window or counter is off by one word would lock one cycle early or late, or report the wrong block on `out_block`. It feeds a word carrying markers at two offsets at once, which exposes a picker that prefers the highest offset. Separate streams cover a missing second marker (a design that locks on one match, or stays stuck in confirmation), two misses followed by a hit (a miss counter that never clears drops lock too early) and a foreign marker (a comparator that ignores the pattern locks wrongly). Idle cycles between words catch a counter that advances on invalid input.

// File: rtl/lane_marker_lock_pkg.sv
package lane_marker_lock_pkg;

   localparam int unsigned BLOCK_BITS  = 66;
   localparam int unsigned MARKER_BITS = 24;
   localparam int unsigned HDR_BITS    = 2;
   localparam logic [1:0]  MARKER_HDR  = 2'b01;

   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_CONFIRM = 2'd1,
      ST_LOCKED  = 2'd2
   } lock_state_e;

endpackage

// File: rtl/lane_marker_offset_scan.sv
module lane_marker_offset_scan #(
   parameter int unsigned BLK_W  = 66,
   parameter int unsigned MARK_W = 24,
   parameter int unsigned HDR_W  = 2,
   parameter logic [HDR_W-1:0] HDR_VAL = 2'b01
) (
   input  logic [2*BLK_W-1:0] window,
   input  logic [MARK_W-1:0]  marker,
   output logic [BLK_W-1:0]   hit_vec
);

   localparam int unsigned FIELD_W = HDR_W + MARK_W;

   if (FIELD_W > BLK_W) begin : g_bad_field
      $error("marker field wider than block");
   end

   for (genvar k = 0; k < BLK_W; k++) begin : g_cmp
      logic [FIELD_W-1:0] field;
      assign field      = window[k +: FIELD_W];
      assign hit_vec[k] = (field[HDR_W-1:0] == HDR_VAL) &&
                          (field[FIELD_W-1:HDR_W] == marker);
   end

endmodule

// File: rtl/lane_marker_low_pick.sv
module lane_marker_low_pick #(
   parameter int unsigned N   = 66,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if ((1 << IDX_W) < N) begin : g_bad_idx
      $error("index width too small for request vector");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/lane_marker_lock_ctrl.sv
module lane_marker_lock_ctrl
   import lane_marker_lock_pkg::*;
#(
   parameter int unsigned BLK_W      = 66,
   parameter int unsigned OFF_W      = 7,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned MISS_LIMIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [BLK_W-1:0] hit_vec,
   input  logic             any_hit,
   input  logic [OFF_W-1:0] pick_idx,
   input  logic [CNT_W-1:0] spacing,
   output logic             locked,
   output logic [OFF_W-1:0] offset
);

   localparam int unsigned MISS_W = (MISS_LIMIT < 2) ? 1 : $clog2(MISS_LIMIT);

   if (MISS_LIMIT < 1) begin : g_bad_miss
      $error("MISS_LIMIT must be at least 1");
   end

   lock_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [MISS_W-1:0] miss_q;
   logic [OFF_W-1:0] off_q;
   logic             due;
   logic             hit_here;

   assign due      = (cnt_q == spacing);
   assign hit_here = hit_vec[off_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         cnt_q   <= '0;
         miss_q  <= '0;
         off_q   <= '0;
      end else if (in_valid) begin
         unique case (state_q)
            ST_HUNT: begin
               if (any_hit) begin
                  off_q   <= pick_idx;
                  cnt_q   <= CNT_W'(1);
                  state_q <= ST_CONFIRM;
               end
            end
            ST_CONFIRM: begin
               if (due) begin
                  cnt_q <= CNT_W'(1);
                  if (hit_here) begin
                     state_q <= ST_LOCKED;
                     miss_q  <= '0;
                  end else begin
                     state_q <= ST_HUNT;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_LOCKED: begin
               if (due) begin
                  cnt_q <= CNT_W'(1);
                  if (hit_here) begin
                     miss_q <= '0;
                  end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                     miss_q  <= '0;
                     state_q <= ST_HUNT;
                  end else begin
                     miss_q <= miss_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

   assign locked = (state_q == ST_LOCKED);
   assign offset = off_q;

   // R4: lock only rises on a valid word that matched at the kept offset
   p_lock_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(in_valid) && $past(hit_here)));

   // R6: miss count never reaches the limit
   p_miss_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q < MISS_W'(MISS_LIMIT));

   // R10: lock never falls on an idle cycle
   p_drop_on_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(in_valid));

   // R9: offset held while locked
   p_offset_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(offset));

endmodule

// File: rtl/lane_marker_align_out.sv
module lane_marker_align_out #(
   parameter int unsigned BLK_W   = 66,
   parameter int unsigned OFF_W   = 7,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*BLK_W-1:0] window,
   input  logic [OFF_W-1:0]   offset,
   input  logic               in_valid,
   input  logic               locked,
   output logic               out_valid,
   output logic [BLK_W-1:0]   out_block
);

   logic [2*BLK_W-1:0] shifted;
   logic [BLK_W-1:0]   sel_blk;

   assign shifted = window >> offset;
   assign sel_blk = shifted[BLK_W-1:0];

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_block <= '0;
         end else begin
            out_valid <= in_valid && locked;
            if (in_valid && locked) out_block <= sel_blk;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid && locked;
      assign out_block = sel_blk;
   end

endmodule

// File: rtl/lane_marker_lock.sv
module lane_marker_lock
   import lane_marker_lock_pkg::*;
#(
   parameter int unsigned BLK_W      = BLOCK_BITS,
   parameter int unsigned MARK_W     = MARKER_BITS,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned MISS_LIMIT = 3,
   parameter bit          OUT_REG    = 1'b1,
   localparam int unsigned OFF_W     = $clog2(BLK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BLK_W-1:0]  in_word,
   input  logic [MARK_W-1:0] lane_marker,
   input  logic [CNT_W-1:0]  spacing,
   output logic              block_lock,
   output logic              marker_lock,
   output logic [OFF_W-1:0]  bit_offset,
   output logic              out_valid,
   output logic [BLK_W-1:0]  out_block
);

   if (BLK_W < HDR_BITS + MARKER_BITS) begin : g_bad_blk
      $error("block narrower than header plus marker");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("spacing counter too narrow");
   end

   logic [BLK_W-1:0]   prev_q;
   logic [2*BLK_W-1:0] window;
   logic [BLK_W-1:0]   hit_vec;
   logic               any_hit;
   logic [OFF_W-1:0]   pick_idx;
   logic               locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_q <= '0;
      else if (in_valid) prev_q <= in_word;
   end

   assign window = {in_word, prev_q};

   lane_marker_offset_scan #(
      .BLK_W  (BLK_W),
      .MARK_W (MARK_W),
      .HDR_W  (HDR_BITS),
      .HDR_VAL(MARKER_HDR)
   ) u_scan (
      .window (window),
      .marker (lane_marker),
      .hit_vec(hit_vec)
   );

   lane_marker_low_pick #(
      .N    (BLK_W),
      .IDX_W(OFF_W)
   ) u_pick (
      .req(hit_vec),
      .any(any_hit),
      .idx(pick_idx)
   );

   lane_marker_lock_ctrl #(
      .BLK_W     (BLK_W),
      .OFF_W     (OFF_W),
      .CNT_W     (CNT_W),
      .MISS_LIMIT(MISS_LIMIT)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .hit_vec (hit_vec),
      .any_hit (any_hit),
      .pick_idx(pick_idx),
      .spacing (spacing),
      .locked  (locked),
      .offset  (bit_offset)
   );

   lane_marker_align_out #(
      .BLK_W  (BLK_W),
      .OFF_W  (OFF_W),
      .OUT_REG(OUT_REG)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .window   (window),
      .offset   (bit_offset),
      .in_valid (in_valid),
      .locked   (locked),
      .out_valid(out_valid),
      .out_block(out_block)
   );

   assign block_lock  = locked;
   assign marker_lock = locked;

   // R3: the picked offset is a real hit and no lower offset hit
   p_lowest_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> (hit_vec[pick_idx] &&
                   ((hit_vec & ((BLK_W'(1) << pick_idx) - BLK_W'(1))) == '0)));

   // R2: a candidate taken from the hunt reports the scanned offset
   p_candidate_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(any_hit) && !$past(locked) &&
       $changed(bit_offset)) |-> (bit_offset == $past(pick_idx)));

endmodule

// File: tb/lane_marker_lock_bench.sv
module lane_marker_lock_bench;

   localparam int BW = 66;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [BW-1:0] in_word = '0;
   logic [23:0]   lane_marker = 24'h9D71A3;
   logic [7:0]    spacing = 8'd8;
   logic          block_lock, marker_lock, out_valid;
   logic [6:0]    bit_offset;
   logic [BW-1:0] out_block;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lane_marker_lock u_lane_marker_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_word    (in_word),
      .lane_marker(lane_marker),
      .spacing    (spacing),
      .block_lock (block_lock),
      .marker_lock(marker_lock),
      .bit_offset (bit_offset),
      .out_valid  (out_valid),
      .out_block  (out_block)
   );

   // vector: [31:24] offset, [23:16] spacing, [15:8] mode, [7:0] idle gap
   // mode 0 periodic, 1 failed confirm, 2 drop, 3 hit between misses, 4 foreign
   localparam logic [31:0] VEC [8] = '{
      {8'd0,  8'd8,  8'd0, 8'd0},
      {8'd17, 8'd8,  8'd0, 8'd1},
      {8'd65, 8'd4,  8'd0, 8'd0},
      {8'd33, 8'd8,  8'd1, 8'd0},
      {8'd12, 8'd8,  8'd2, 8'd0},
      {8'd50, 8'd6,  8'd3, 8'd0},
      {8'd7,  8'd8,  8'd4, 8'd0},
      {8'd40, 8'd16, 8'd0, 8'd0}
   };

   int cur_off, cur_n, cur_mode;

   task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                      input logic [BW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_mk(input int j);
      case (cur_mode)
         0, 4: return (j >= 2) && ((j - 2) % cur_n == 0);
         1: return (j == 2) || ((j >= cur_n + 3) && ((j - cur_n - 3) % cur_n == 0));
         2: return (j == 2) || (j == cur_n + 2);
         3: return (j == 2) || (j == cur_n + 2) || (j == 4 * cur_n + 2);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [63:0] mix(input int j);
      logic [63:0] h;
      h = (64'(j) + 64'(cur_off * 977 + cur_mode)) * 64'h9E3779B97F4A7C15;
      return h ^ (h >> 29);
   endfunction

   function automatic logic [BW-1:0] blk(input int j);
      logic [63:0] h;
      h = mix(j);
      if (is_mk(j))
         return {h[39:0], (cur_mode == 4) ? (lane_marker ^ 24'h000100) : lane_marker, 2'b01};
      return {h, 2'b10};
   endfunction

   function automatic logic [BW-1:0] word_at(input int t);
      logic [BW-1:0] w;
      w = '0;
      for (int i = 0; i < BW; i++) begin
         int p;
         p = BW * t + i;
         if (p >= cur_off) begin
            logic [BW-1:0] b;
            b = blk((p - cur_off) / BW);
            w[i] = b[(p - cur_off) % BW];
         end
      end
      return w;
   endfunction

   function automatic bit exp_lock(input int t);
      case (cur_mode)
         0: return t >= cur_n + 3;
         1: return t >= 2 * cur_n + 4;
         2: return (t >= cur_n + 3) && (t < 4 * cur_n + 3);
         3: return (t >= cur_n + 3) && (t < 7 * cur_n + 3);
         default: return 1'b0;
      endcase
   endfunction

   task automatic step(input logic v, input logic [BW-1:0] w);
      @(negedge clk);
      in_valid = v;
      in_word  = w;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_word  = '0;
      repeat (2) @(posedge clk);
      #1;
      // R1: reset state
      chk(!block_lock && !marker_lock, "R1 lock flags", {block_lock, marker_lock}, '0);
      chk(!out_valid, "R1 out_valid", out_valid, '0);
      chk(bit_offset == 0, "R1 offset", bit_offset, '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // vector walk: R2 R4 R5 R6 R7 R8 R9 R10 R11
      for (int v = 0; v < 8; v++) begin
         int last;
         cur_off  = int'(VEC[v][31:24]);
         cur_n    = int'(VEC[v][23:16]);
         cur_mode = int'(VEC[v][15:8]);
         spacing  = VEC[v][23:16];
         do_reset();
         last = 8 * cur_n + 4;
         for (int t = 0; t <= last; t++) begin
            bit el;
            el = exp_lock(t);
            step(1'b1, word_at(t));
            chk(block_lock == el && marker_lock == el,
                "R4/R5/R6/R7/R8/R11 lock", {block_lock, marker_lock}, {el, el});
            if (el) chk(bit_offset == 7'(cur_off), "R2 offset", bit_offset, 7'(cur_off));
            chk(out_valid == (t >= 1 && exp_lock(t - 1)), "R9 out_valid",
                out_valid, (t >= 1 && exp_lock(t - 1)));
            if (t >= 1 && exp_lock(t - 1))
               chk(out_block == blk(t - 1), "R9 out_block", out_block, blk(t - 1));
            if (VEC[v][7:0] != 0) begin
               step(1'b0, {BW{1'b1}});
               chk(block_lock == el, "R10 idle lock", block_lock, el);
               chk(!out_valid, "R10 idle out_valid", out_valid, '0);
            end
         end
      end

      // R3: two markers in one word, lowest offset wins
      begin
         logic [BW-1:0] a, b;
         a = '0;
         a[5 +: 26]  = {lane_marker, 2'b01};
         a[37 +: 26] = {lane_marker, 2'b01};
         b = '0;
         b[5 +: 26]  = {lane_marker, 2'b01};
         spacing = 8'd4;
         do_reset();
         step(1'b1, a);
         step(1'b1, '0);
         chk(bit_offset == 7'd5, "R3 lowest offset", bit_offset, 7'd5);
         chk(!block_lock, "R3 no lock on one match", block_lock, '0);
         step(1'b1, '0);
         step(1'b1, '0);
         step(1'b1, b);
         chk(!block_lock, "R4 not before confirm", block_lock, '0);
         step(1'b1, '0);
         chk(block_lock && marker_lock, "R4 lock after second match",
             {block_lock, marker_lock}, 2'b11);
         chk(bit_offset == 7'd5, "R3 offset kept", bit_offset, 7'd5);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule